// File: doc/BRIEF.md
# Gated Multi-Pattern Test Sequence Generator

This block produces a test-pattern bit stream that stands in for PCM payload during line testing. A single shift register serves four pseudo-random sequences: a 4-stage, a 15-stage with its output inverted, a 23-stage, and a 20-stage sequence whose output is zero-limited. A fifth choice sends a programmable byte, MSB first. The stream comes out as one serial bit and as a byte that holds the last eight bits sent.

The generator moves forward only on a step. In per-timeslot mode a step happens when the advance strobe is high. Timeslots that are not selected leave the sequence where it stopped, so one unbroken sequence is laid across slots that need not be next to each other. In whole-channel mode the generator steps on every clock and replaces every bit of the channel, whether framed or unframed. No errors are ever inserted into the pattern.

Top module: `test_pattern_gen`

## Requirements
- R1: While reset is low, and after it is released, `pat_byte` is 0. The registered select is code 0. The shift register holds all ones, so `pat_bit` is 1.
- R2: Select code 0 gives the sequence of x^4+x^3+1. The register holds s[3:0]. The output is s[3]. A step shifts the register left and brings s[3]^s[2] in at bit 0.
- R3: Select code 1 gives the sequence of x^15+x^14+1 in the same shift form. The output is the inverse of s[14].
- R4: Select code 2 gives the sequence of x^23+x^18+1. The output is s[22].
- R5: Select code 3 gives the sequence of x^20+x^17+1. Its output is s[19] OR (s[18:5] all zero), so no more than 14 zeros in a row are ever sent.
- R6: Select codes 4 to 7 send `fill_byte` MSB first. Bit 7-p is sent, where p is a 3-bit pointer. The pointer advances by one only on a step.
- R7: With `chan_mode`=0, a step happens only in a cycle where `adv_en`=1. In other cycles `pat_bit` and `pat_byte` hold their values.
- R8: With `chan_mode`=1, a step happens on every clock, whatever the value of `adv_en`.
- R9: Take a cycle in which `pat_sel` differs from the registered select. In that cycle nothing steps, and the output still follows the old pattern. At the next edge the new select is registered, the register is loaded with all ones over the new length, and the pointer is set to 0.
- R10: Each step shifts the `pat_bit` of that cycle into bit 0 of `pat_byte`, and the older bits move up by one place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low. It takes effect at once and is released in step with the clock. |
| pat_sel | input | 3 | Pattern select: 0 = 4-stage, 1 = 15-stage inverted, 2 = 23-stage, 3 = zero-limited 20-stage, 4 to 7 = fixed byte |
| fill_byte | input | 8 | Programmable byte for the fixed pattern |
| chan_mode | input | 1 | 0 = per-timeslot stepping, 1 = whole-channel stepping |
| adv_en | input | 1 | Step strobe, used in per-timeslot mode |
| pat_bit | output | 1 | Current pattern bit |
| pat_byte | output | 8 | The last eight bits sent, the newest at bit 0 |

## Verification
The bench steps per-timeslot mode with sparse, irregular strobe patterns. A design that kept running through slots that were not selected, or that lost a bit at a gap, would fall out of step with the model within a few bits. The bench runs the zero-limited sequence long enough to meet runs of more than 14 raw zeros, and it tracks the longest run of zeros seen. If the lookahead window were off by one, that run would grow to 15 or more, or the forced ones would come in the wrong places. The bench also changes the select in the middle of a run, including from one fixed code to another. A design that stepped in the change cycle, kept the old seed, or did not reset the byte pointer would send the wrong first bits of the new pattern.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned SR_W       = 23;
  localparam int unsigned IDX_W      = $clog2(SR_W);
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PTR_W      = $clog2(BYTE_W);
  localparam int unsigned QRSS_LEN   = 20;
  localparam int unsigned QRSS_GUARD = 14;
  localparam int unsigned RUN_W      = $clog2(QRSS_GUARD + 2);

  localparam logic [SEL_W-1:0] SEL_P4   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_P15  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_P23  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_QRSS = 3'd3;
  localparam logic [SEL_W-1:0] SEL_FIX  = 3'd4;

  typedef struct packed {
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] tap;
    logic             inv;
    logic             zlim;
  } poly_t;

  function automatic poly_t poly_of(input logic [SEL_W-1:0] sel);
    poly_t p;
    case (sel)
      SEL_P15:  p = '{len: IDX_W'(15), tap: IDX_W'(14), inv: 1'b1, zlim: 1'b0};
      SEL_P23:  p = '{len: IDX_W'(23), tap: IDX_W'(18), inv: 1'b0, zlim: 1'b0};
      SEL_QRSS: p = '{len: IDX_W'(QRSS_LEN), tap: IDX_W'(17), inv: 1'b0, zlim: 1'b1};
      default:  p = '{len: IDX_W'(4),  tap: IDX_W'(3),  inv: 1'b0, zlim: 1'b0};
    endcase
    return p;
  endfunction

  function automatic logic [SR_W-1:0] seed_of(input logic [IDX_W-1:0] len);
    logic [SR_W-1:0] m;
    for (int i = 0; i < SR_W; i++) m[i] = (i < int'(len));
    return m;
  endfunction
endpackage

// File: rtl/tpg_rst_sync.sv
`timescale 1ns/1ps
module tpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tpg_lfsr_core.sv
`timescale 1ns/1ps
module tpg_lfsr_core
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [SEL_W-1:0] seed_sel,
  input  logic             step,
  input  logic             reseed,
  output logic             bit_o
);
  poly_t           cur;
  logic [SR_W-1:0] sr_q, sr_d, mask, seed_new, shifted;
  logic            raw, fb, guard_zero;
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    cur        = poly_of(sel);
    mask       = seed_of(cur.len);
    seed_new   = seed_of(poly_of(seed_sel).len);
    raw        = sr_q[cur.len - IDX_W'(1)];
    fb         = raw ^ sr_q[cur.tap - IDX_W'(1)];
    shifted    = {sr_q[SR_W-2:0], fb} & mask;
    guard_zero = ~|sr_q[QRSS_LEN-2 -: QRSS_GUARD];
    bit_o      = cur.zlim ? (raw | guard_zero) : (raw ^ cur.inv);
  end

  always_comb begin
    sr_d  = sr_q;
    run_d = run_q;
    if (reseed) begin
      sr_d  = seed_new;
      run_d = '0;
    end else if (step) begin
      sr_d = ((sr_q & mask) == '0) ? mask : shifted;
      if (cur.zlim) begin
        if (bit_o)                     run_d = '0;
        else if (run_q != {RUN_W{1'b1}}) run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '1;
      run_q <= '0;
    end else begin
      sr_q  <= sr_d;
      run_q <= run_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reseed) |=> $stable(sr_q)); // R7
  AST_RESEED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> ((sr_q & mask) == mask)); // R9
  AST_NO_ZERO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sr_q & mask) != '0)); // R4
  AST_QRSS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cur.zlim |-> (run_q <= RUN_W'(QRSS_GUARD))); // R5
endmodule

// File: rtl/tpg_fill_src.sv
`timescale 1ns/1ps
module tpg_fill_src
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] fill_i,
  input  logic              step,
  input  logic              reseed,
  output logic              bit_o
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(BYTE_W - 1);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (reseed)    ptr_d = '0;
    else if (step) ptr_d = ptr_q + 1'b1;
    bit_o = fill_i[TOP_IDX - ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_FILL_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1))); // R6
  AST_FILL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (ptr_q == '0)); // R9
endmodule

// File: rtl/tpg_byte_asm.sv
`timescale 1ns/1ps
module tpg_byte_asm
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] byte_q, byte_d;

  always_comb begin
    byte_d = byte_q;
    if (step) byte_d = {byte_q[BYTE_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_q <= '0;
    else        byte_q <= byte_d;
  end

  assign byte_o = byte_q;

  AST_BYTE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (byte_q[BYTE_W-1:1] == $past(byte_q[BYTE_W-2:0]))); // R10
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(byte_q)); // R7
endmodule

// File: rtl/test_pattern_gen.sv
`timescale 1ns/1ps
module test_pattern_gen
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  pat_sel,
  input  logic [BYTE_W-1:0] fill_byte,
  input  logic              chan_mode,
  input  logic              adv_en,
  output logic              pat_bit,
  output logic [BYTE_W-1:0] pat_byte
);
  logic             rst_n_int;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_chg, advance, step, is_fix;
  logic             lfsr_bit, fill_bit;

  tpg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  always_comb begin
    sel_chg = (pat_sel != sel_q);
    sel_d   = pat_sel;
    advance = chan_mode | adv_en;
    step    = advance & ~sel_chg;
    is_fix  = (sel_q >= SEL_FIX);
    pat_bit = is_fix ? fill_bit : lfsr_bit;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sel_q <= SEL_P4;
    else            sel_q <= sel_d;
  end

  tpg_lfsr_core u_lfsr (
    .clk(clk), .rst_n(rst_n_int), .sel(sel_q), .seed_sel(pat_sel),
    .step(step & ~is_fix), .reseed(sel_chg), .bit_o(lfsr_bit)
  );

  tpg_fill_src u_fill (
    .clk(clk), .rst_n(rst_n_int), .fill_i(fill_byte),
    .step(step & is_fix), .reseed(sel_chg), .bit_o(fill_bit)
  );

  tpg_byte_asm u_byte (
    .clk(clk), .rst_n(rst_n_int), .step(step), .bit_i(pat_bit), .byte_o(pat_byte)
  );

  AST_WHOLE_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (chan_mode && !sel_chg) |=> (pat_byte[0] == $past(pat_bit))); // R8
  AST_CHG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n_int)
    sel_chg |=> $stable(pat_byte)); // R9
endmodule

// File: tb/sim_test_pattern_gen.sv
`timescale 1ns/1ps
module sim_test_pattern_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pat_sel;
  logic [7:0] fill_byte;
  logic       chan_mode, adv_en;
  logic       pat_bit;
  logic [7:0] pat_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int unsigned m_st;
  int          m_sel, m_ptr, m_byte;
  int          zrun, zmax;

  always #5 clk = ~clk;

  test_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .fill_byte(fill_byte),
    .chan_mode(chan_mode), .adv_en(adv_en), .pat_bit(pat_bit), .pat_byte(pat_byte)
  );

  function automatic int plen(input int s);
    case (s) 1: return 15; 2: return 23; 3: return 20; default: return 4; endcase
  endfunction
  function automatic int ptap(input int s);
    case (s) 1: return 14; 2: return 18; 3: return 17; default: return 3; endcase
  endfunction

  function automatic int model_bit(input int f);
    int n, r;
    if (m_sel >= 4) return (f >> (7 - m_ptr)) & 1;
    n = plen(m_sel);
    r = int'((m_st >> (n - 1)) & 1);
    if (m_sel == 1) return r ^ 1;
    if (m_sel == 3 && ((m_st >> 5) & 32'h3fff) == 0) return 1;
    return r;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input int s, input int f, input int m, input int e, input string tag);
    int b, n, t, fb;
    int unsigned mask;
    pat_sel = 3'(s); fill_byte = 8'(f); chan_mode = m[0]; adv_en = e[0];
    #1;
    b = model_bit(f);
    check(tag, "pat_bit", int'(pat_bit), b);
    check("R10", "pat_byte", int'(pat_byte), m_byte);
    if (s != m_sel) begin
      m_sel = s;
      m_st  = (32'd1 << plen(s)) - 1;
      m_ptr = 0;
      zrun  = 0;
    end else if ((m | e) != 0) begin
      m_byte = ((m_byte << 1) | b) & 8'hff;
      if (m_sel >= 4) m_ptr = (m_ptr + 1) % 8;
      else begin
        n = plen(m_sel); t = ptap(m_sel);
        mask = (32'd1 << n) - 1;
        if ((m_st & mask) == 0) m_st = mask;
        else begin
          fb = int'(((m_st >> (n - 1)) ^ (m_st >> (t - 1))) & 1);
          m_st = ((m_st << 1) | fb) & mask;
        end
        if (m_sel == 3) begin
          if (pat_bit) zrun = 0; else zrun++;
          if (zrun > zmax) zmax = zrun;
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pat_sel = 3'd0; fill_byte = 8'h00; chan_mode = 1'b0; adv_en = 1'b0;
    m_st = 32'h7fffff; m_sel = 0; m_ptr = 0; m_byte = 0; zrun = 0; zmax = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pat_byte in reset", int'(pat_byte), 0);
    check("R1", "pat_bit in reset", int'(pat_bit), 1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R1");
    // R7: strobe low holds everything
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, "R7");
    // R2 contiguous, then gapped per-timeslot R7
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, "R2");
    for (int i = 0; i < 60; i++) cyc(0, 0, 0, int'((i % 3 == 0) || (i % 7 == 2)), "R7");
    // R9 change to 15-stage inverted, R3
    cyc(1, 0, 1, 1, "R9");
    for (int i = 0; i < 300; i++) cyc(1, 0, 1, 0, "R3");
    cyc(2, 0, 0, 1, "R9");
    for (int i = 0; i < 300; i++) cyc(2, 0, 0, int'(i % 5 != 3), "R4");
    // R8: whole channel ignores a low strobe
    for (int i = 0; i < 60; i++) cyc(2, 0, 1, 0, "R8");
    // R5 zero-limited sequence
    cyc(3, 0, 1, 0, "R9");
    for (int i = 0; i < 40000; i++) cyc(3, 0, 1, 0, "R5");
    for (int i = 0; i < 200; i++) cyc(3, 0, 0, int'(i % 4 == 1), "R5");
    check("R5", "longest zero run <= 14", int'(zmax <= 14), 1);
    // R6 fixed byte, gapped
    cyc(4, 8'hA5, 0, 1, "R9");
    for (int i = 0; i < 40; i++) cyc(4, 8'hA5, 0, int'(i % 3 != 1), "R6");
    for (int i = 0; i < 3; i++) cyc(4, 8'h3C, 1, 0, "R6");
    cyc(6, 8'h3C, 1, 0, "R9");
    for (int i = 0; i < 24; i++) cyc(6, 8'h3C, 1, 0, "R6");
    cyc(7, 8'h81, 0, 0, "R9");
    for (int i = 0; i < 20; i++) cyc(7, 8'h81, 0, int'(i % 2 == 0), "R6");
    // back to 4-stage, contiguous
    cyc(0, 0, 0, 1, "R9");
    for (int i = 0; i < 30; i++) cyc(0, 0, 1, 1, "R2");
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule